// File: doc/BRIEF.md
# External Interrupt Trigger Controller

The controller watches a parameterised set of external interrupt pins (32 by default), all sampled in the system clock domain. Software picks one trigger condition for each pin: an active-low level, an active-high level, a falling edge, a rising edge or either edge. When that condition occurs, the pin's pending flag is latched. A per-pin mask then decides whether the flag reaches the interrupt outputs, which feed a downstream vectored interrupt controller.

The low pins (0 to 15) each drive their own output line. The remaining pins share a single ORed line. Software reads their pending banks to find which pin fired, and writes ones to acknowledge. Each pin passes through a two-flop synchronizer. A third flop keeps the previous synchronized value, which is used for edge detection. Registers are 32 bits wide and each one covers a bank of eight pins. A plain register bus gives access to them and returns read data one cycle after the request.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every trigger field reads 0, every filter register reads 0, every mask register reads 0xFF, every pending register reads 0, and all interrupt outputs are low.
- R2: The trigger register of bank b sits at byte address 0x000 + 4*b and holds 32 read/write bits. Pin p owns the 4-bit field at bits 4*(p mod 8)+3 down to 4*(p mod 8), in bank p/8.
- R3: Trigger code 0 (low level) sets a pin's pending bit on every cycle in which its synchronized input is 0. Code 1 (high level) does the same when the input is 1. A level that is still active re-sets the bit after software clears it.
- R4: Code 2 sets pending on a 1-to-0 transition, code 3 on a 0-to-1 transition and code 4 on either transition. Only the low three bits of a field are decoded, so bit 3 has no effect. Codes 5, 6 and 7 never set pending.
- R5: A pin change that is present at clock edge k is latched into the pending bit at edge k+2. The pin's output rises after that edge, and not after edge k+1.
- R6: The pending register of bank b is at 0x140 + 4*b, with pin p at bit p mod 8. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. If a trigger and a clear fall on the same cycle, the trigger wins.
- R7: The mask register of bank b is at 0x100 + 4*b, with pin p at bit p mod 8. A mask bit of 1 keeps the pin off every output, but the pending bit is still set. Masking a pending pin drops its output on the next cycle.
- R8: For pins 0 to 15, irq_direct[p] is high exactly while pin p is pending and unmasked. No other pin affects that line.
- R9: irq_shared is high while any pin from 16 to 31 is both pending and unmasked.
- R10: The registers at 0x080 + 4*b are 32-bit read/write storage with no effect on triggering or outputs. Any address outside the four register groups reads 0 and ignores writes, and so does any address whose two low bits are not 00.
- R11: A read request (bus_en=1, bus_we=0) at clock edge k drives bus_rvalid high after edge k, with that address's data on bus_rdata. A write request does not raise bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pins | input | 32 | External interrupt inputs |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| irq_direct | output | 16 | Dedicated lines for pins 0 to 15 |
| irq_shared | output | 1 | Combined line for pins 16 to 31 |

## Verification
The hardest case to reach is a clear and a trigger landing in the same cycle. It only happens when a level-triggered pin is still active while software writes its pending bit, so the bench holds such a pin at its active level, issues the clear, and then reads back a pending bit that is set again. Pending bits that are set but masked never show on an output, so the bench observes them through pending-register reads. It then changes the mask and watches the output follow. Exact latency is measured for one rising edge, cycle by cycle, at the output.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum logic [2:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  // Decide whether a pin's trigger condition holds this cycle.
  function automatic logic trig_hit(input logic [2:0] code, input logic cur, input logic prev);
    logic r;
    case (code)
      TRIG_LOW:  r = !cur;
      TRIG_HIGH: r = cur;
      TRIG_FALL: r = prev && !cur;
      TRIG_RISE: r = !prev && cur;
      TRIG_BOTH: r = prev ^ cur;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W    = 32,
  parameter bit IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stage1, stage2, stage3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= {W{IDLE}};
      stage2 <= {W{IDLE}};
      stage3 <= {W{IDLE}};
    end else begin
      stage1 <= raw;
      stage2 <= stage1;
      stage3 <= stage2;
    end
  end

  assign cur  = stage2;
  assign prev = stage3;
endmodule

// File: rtl/eirq_bank.sv
module eirq_bank
  import eirq_pkg::*;
#(
  parameter int PINS = 8,
  parameter int FW   = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] cur,
  input  logic [PINS-1:0] prev,
  input  logic            we_cfg,
  input  logic            we_flt,
  input  logic            we_msk,
  input  logic            we_pnd,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   cfg_q,
  output logic [DW-1:0]   flt_q,
  output logic [PINS-1:0] msk_q,
  output logic [PINS-1:0] pnd_q
);
  logic [PINS-1:0] hit;
  logic [PINS-1:0] clr;

  assign clr = we_pnd ? wdata[PINS-1:0] : '0;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign hit[i] = trig_hit(cfg_q[i*FW +: 3], cur[i], prev[i]);

    // R5: a pending bit only rises because a trigger was seen
    p_rise_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pnd_q[i]) |-> $past(hit[i]));
    // R6: a pending bit only falls after a one was written to it
    p_fall_needs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pnd_q[i]) |-> $past(clr[i]));
    // R3: an active low level always leaves the bit set, even through a clear
    p_low_level_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[i*FW +: 3] == 3'd0 && !cur[i]) |=> pnd_q[i]);
    // R4: unused codes never fire
    p_unused_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[i*FW +: 3] > 3'd4) |-> !hit[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      flt_q <= '0;
      msk_q <= '1;
      pnd_q <= '0;
    end else begin
      if (we_cfg) cfg_q <= wdata;
      if (we_flt) flt_q <= wdata;
      if (we_msk) msk_q <= wdata[PINS-1:0];
      pnd_q <= hit | (pnd_q & ~clr);
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_BANKS   = 4,
  parameter int BANK_PINS   = 8,
  parameter int DIRECT_PINS = 16,
  parameter int FIELD_W     = 4,
  parameter int AW          = 12,
  parameter int DW          = 32,
  parameter logic [AW-1:0] CFG_BASE = 12'h000,
  parameter logic [AW-1:0] FLT_BASE = 12'h080,
  parameter logic [AW-1:0] MSK_BASE = 12'h100,
  parameter logic [AW-1:0] PND_BASE = 12'h140
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_BANKS*BANK_PINS-1:0] ext_pins,
  input  logic                           bus_en,
  input  logic                           bus_we,
  input  logic [AW-1:0]                  bus_addr,
  input  logic [DW-1:0]                  bus_wdata,
  output logic                           bus_rvalid,
  output logic [DW-1:0]                  bus_rdata,
  output logic [DIRECT_PINS-1:0]         irq_direct,
  output logic                           irq_shared
);
  localparam int NPINS   = NUM_BANKS * BANK_PINS;
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int SLOT_SH = BANK_W + 2;

  function automatic logic in_region(input logic [AW-1:0] a, input logic [AW-1:0] base);
    return (a[AW-1:SLOT_SH] == base[AW-1:SLOT_SH]) && (a[1:0] == 2'b00);
  endfunction

  logic [NPINS-1:0] cur, prev;
  logic [NPINS-1:0] pend_flat, mask_flat, active;
  logic [BANK_W-1:0] bank_sel;
  logic sel_cfg, sel_flt, sel_msk, sel_pnd, wr_req, rd_req;
  logic [NUM_BANKS-1:0] we_cfg, we_flt, we_msk, we_pnd;
  logic [DW-1:0] cfg_all [NUM_BANKS];
  logic [DW-1:0] flt_all [NUM_BANKS];
  logic [BANK_PINS-1:0] msk_all [NUM_BANKS];
  logic [BANK_PINS-1:0] pnd_all [NUM_BANKS];
  logic [DW-1:0] rd_next;

  eirq_sync #(.W(NPINS), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(ext_pins), .cur(cur), .prev(prev));

  assign bank_sel = bus_addr[SLOT_SH-1:2];
  assign sel_cfg  = in_region(bus_addr, CFG_BASE);
  assign sel_flt  = in_region(bus_addr, FLT_BASE);
  assign sel_msk  = in_region(bus_addr, MSK_BASE);
  assign sel_pnd  = in_region(bus_addr, PND_BASE);
  assign wr_req   = bus_en && bus_we;
  assign rd_req   = bus_en && !bus_we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic here;
    assign here      = wr_req && (bank_sel == BANK_W'(b));
    assign we_cfg[b] = here && sel_cfg;
    assign we_flt[b] = here && sel_flt;
    assign we_msk[b] = here && sel_msk;
    assign we_pnd[b] = here && sel_pnd;

    eirq_bank #(.PINS(BANK_PINS), .FW(FIELD_W), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .cur(cur[b*BANK_PINS +: BANK_PINS]),
      .prev(prev[b*BANK_PINS +: BANK_PINS]),
      .we_cfg(we_cfg[b]), .we_flt(we_flt[b]), .we_msk(we_msk[b]), .we_pnd(we_pnd[b]),
      .wdata(bus_wdata),
      .cfg_q(cfg_all[b]), .flt_q(flt_all[b]),
      .msk_q(msk_all[b]), .pnd_q(pnd_all[b]));

    assign pend_flat[b*BANK_PINS +: BANK_PINS] = pnd_all[b];
    assign mask_flat[b*BANK_PINS +: BANK_PINS] = msk_all[b];
  end

  always_comb begin
    rd_next = '0;
    if (sel_cfg)      rd_next = cfg_all[bank_sel];
    else if (sel_flt) rd_next = flt_all[bank_sel];
    else if (sel_msk) rd_next[BANK_PINS-1:0] = msk_all[bank_sel];
    else if (sel_pnd) rd_next[BANK_PINS-1:0] = pnd_all[bank_sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_next;
    end
  end

  assign active     = pend_flat & ~mask_flat;
  assign irq_direct = active[DIRECT_PINS-1:0];
  assign irq_shared = |active[NPINS-1:DIRECT_PINS];

  // R11: read data is flagged only after a read request
  p_rvalid_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_en && !bus_we));
  // R9: the shared line needs a pending source among the upper pins
  p_shared_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared |-> (|pend_flat[NPINS-1:DIRECT_PINS]));

  for (genvar i = 0; i < DIRECT_PINS; i++) begin : g_direct
    localparam int BK = i / BANK_PINS;
    localparam int PB = i % BANK_PINS;
    // R7: setting a mask bit silences that line from the next cycle
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we_msk[BK] && bus_wdata[PB]) |=> !irq_direct[i]);
    // R8: a dedicated line only rises when its pin is pending
    p_direct_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_direct[i]) |-> pend_flat[i]);
  end
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ext_pins = '1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [15:0] irq_direct;
  logic        irq_shared;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ext_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_pins(ext_pins),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .irq_direct(irq_direct), .irq_shared(irq_shared));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read value when the design presents data.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 actual=%h expected=no read outstanding", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  // Driver: issues a read and queues what it should return.
  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    ext_pins[p] = v;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq_direct", {16'h0, irq_direct}, 32'h0);
    check("R1 irq_shared", {31'h0, irq_shared}, 32'h0);
    for (int b = 0; b < 4; b++) begin
      bus_read(12'(4*b),          32'h0,  "R1 trigger reset");
      bus_read(12'(12'h080+4*b),  32'h0,  "R1 filter reset");
      bus_read(12'(12'h100+4*b),  32'hFF, "R1 mask reset");
      bus_read(12'(12'h140+4*b),  32'h0,  "R1 pending reset");
    end

    // R2 trigger register storage (no level-high fields, pins idle high)
    bus_write(12'h004, 32'h87654320);
    check("R11 no rvalid on write", {31'h0, bus_rvalid}, 32'h0);
    bus_read(12'h004, 32'h87654320, "R2 readback");
    bus_write(12'h004, 32'h0);
    bus_read(12'h144, 32'h0, "R4 no spurious pending");

    // Bank 0: pin0 rise, pin1 fall, pin2 both, pin3 code5, pin4 code 0xB,
    // pin5 code6, pin6 code7, pin7 low level
    bus_write(12'h100, 32'h00);
    bus_write(12'h000, 32'h076B5423);

    set_pin(0, 1'b0);
    check("R4 rise ignores fall", {31'h0, irq_direct[0]}, 32'h0);
    // R5 latency of one rising edge
    @(negedge clk); ext_pins[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R5 not yet at k+1", {31'h0, irq_direct[0]}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R5 set at k+2", {31'h0, irq_direct[0]}, 32'h1);
    bus_write(12'h140, 32'h01);
    check("R6 clear drops line", {31'h0, irq_direct[0]}, 32'h0);
    bus_read(12'h140, 32'h0, "R6 cleared");

    set_pin(1, 1'b0);
    check("R4 falling edge", {31'h0, irq_direct[1]}, 32'h1);
    bus_write(12'h140, 32'h00);
    check("R6 zero write keeps", {31'h0, irq_direct[1]}, 32'h1);
    bus_write(12'h140, 32'h01);
    check("R6 other bit keeps", {31'h0, irq_direct[1]}, 32'h1);
    bus_read(12'h140, 32'h02, "R6 only pin1 pending");
    set_pin(1, 1'b1);
    bus_read(12'h140, 32'h02, "R4 fall ignores rise");
    bus_write(12'h140, 32'h02);

    set_pin(2, 1'b0);
    check("R4 both edges fall", {31'h0, irq_direct[2]}, 32'h1);
    bus_write(12'h140, 32'h04);
    check("R6 clear pin2", {31'h0, irq_direct[2]}, 32'h0);
    set_pin(2, 1'b1);
    check("R4 both edges rise", {31'h0, irq_direct[2]}, 32'h1);
    bus_write(12'h140, 32'h04);

    set_pin(3, 1'b0);
    set_pin(3, 1'b1);
    check("R4 code5 silent", {31'h0, irq_direct[3]}, 32'h0);

    set_pin(4, 1'b0);
    check("R4 bit3 ignored fall", {31'h0, irq_direct[4]}, 32'h0);
    set_pin(4, 1'b1);
    check("R4 bit3 ignored rise", {31'h0, irq_direct[4]}, 32'h1);
    bus_write(12'h140, 32'h10);

    set_pin(5, 1'b0); set_pin(6, 1'b0);
    set_pin(5, 1'b1); set_pin(6, 1'b1);
    check("R4 codes 6 and 7 silent", {30'h0, irq_direct[6:5]}, 32'h0);
    bus_read(12'h140, 32'h0, "R4 bank0 idle");

    set_pin(7, 1'b0);
    check("R3 low level", {31'h0, irq_direct[7]}, 32'h1);
    bus_write(12'h140, 32'h80);
    bus_read(12'h140, 32'h80, "R6 trigger wins over clear");
    set_pin(7, 1'b1);
    bus_write(12'h140, 32'h80);
    bus_read(12'h140, 32'h0, "R3 level gone");

    // R7 / R8 masking on bank 1
    set_pin(8, 1'b0);
    check("R7 masked line low", {31'h0, irq_direct[8]}, 32'h0);
    bus_read(12'h144, 32'h01, "R7 pending despite mask");
    bus_write(12'h104, 32'hFE);
    check("R8 unmask shows", {16'h0, irq_direct}, 32'h0100);
    set_pin(8, 1'b1);
    bus_write(12'h144, 32'h01);
    check("R8 cleared", {16'h0, irq_direct}, 32'h0);

    // R3 high level on pin9
    bus_write(12'h004, 32'h00000010);
    settle();
    bus_read(12'h144, 32'h02, "R3 high level");
    check("R7 pin9 masked", {31'h0, irq_direct[9]}, 32'h0);
    bus_write(12'h004, 32'h0);
    bus_write(12'h144, 32'h02);
    bus_read(12'h144, 32'h0, "R3 high level off");

    // R9 shared line
    bus_write(12'h10C, 32'h7F);
    set_pin(20, 1'b0);
    check("R9 masked upper pin", {31'h0, irq_shared}, 32'h0);
    bus_read(12'h148, 32'h10, "R9 pending pin20");
    set_pin(31, 1'b0);
    check("R9 shared high", {31'h0, irq_shared}, 32'h1);
    check("R8 direct unaffected", {16'h0, irq_direct}, 32'h0);
    bus_write(12'h10C, 32'hFF);
    check("R7 mask drops shared", {31'h0, irq_shared}, 32'h0);
    bus_write(12'h10C, 32'h7F);
    set_pin(31, 1'b1);
    check("R9 latched after level ends", {31'h0, irq_shared}, 32'h1);
    bus_write(12'h14C, 32'h80);
    check("R9 shared cleared", {31'h0, irq_shared}, 32'h0);
    set_pin(20, 1'b1);
    bus_write(12'h148, 32'h10);
    bus_read(12'h148, 32'h0, "R6 bank2 clear");

    // R10 filter storage and unmapped space
    bus_write(12'h088, 32'hDEADBEEF);
    bus_read(12'h088, 32'hDEADBEEF, "R10 filter storage");
    check("R10 no output effect", {15'h0, irq_shared, irq_direct}, 32'h0);
    bus_write(12'h200, 32'h12345678);
    bus_read(12'h200, 32'h0, "R10 unmapped read");
    bus_read(12'h0C0, 32'h0, "R10 gap read");
    bus_write(12'h105, 32'h00);
    bus_read(12'h104, 32'hFE, "R10 unaligned write ignored");

    repeat (3) @(negedge clk);
    check("R11 all reads answered", 32'(exp_q.size()), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule